// File: doc/BRIEF.md
# Interrupt Enable and Gating Controller

This block sits next to a processor core. It decides which pending interrupt, if any, is taken in the current cycle. It keeps a per-line enable register and a set of latched pending flags. Software reaches both through a small register port, and can raise or drop flags by hand through write-only set and clear registers.

Line 0 is the reset interrupt and cannot be disabled. Line 1 is the nonmaskable interrupt (NMI). Lines 4 through 15 are maskable. Lines 2 and 3 are reserved.

A sticky NMI-enable bit gates every interrupt except reset. Software can set this bit but never clear it. It drops on its own when an NMI is taken and comes back on a write of 1 or on the NMI-return strobe. Each cycle the controller combines the flags, the enables, the global enable input and the NMI enable. When something is eligible, it raises a one-cycle take pulse with the 4-bit line index.

Top module: `irq_gate_ctrl`

## Requirements
- R1: Enable register bit 0 (reset) always reads 1, and writing it has no effect.
- R2: Enable register bits 4..15 are read/write maskable enables that reset to 0.
- R3: Enable bit 1 (NMI enable) resets to 0. A register write of 1 sets it. A write of 0 leaves it unchanged.
- R4: The NMI enable clears in the cycle after an NMI is taken. This also holds when a write of 1 to it lands in that same cycle.
- R5: A one-cycle pulse on nmi_ret_i sets the NMI enable.
- R6: While the NMI enable is 0, no interrupt other than line 0 is taken. A pending line 0 is still taken.
- R7: A maskable line k (4..15) is taken only if the NMI enable, gie_i and enable bit k are all 1.
- R8: Bits 2, 3 and 16..31 read as 0 in both the enable and flag registers, and writes to them have no effect.
- R9: A 0-to-1 transition on irq_i[k] sets flag k one clock later. A line held high does not set the flag again once the flag is cleared.
- R10: Address 2 (set) writes set the flags whose data bits are 1. Address 3 (clear) writes clear them. An input edge and a clear that hit the same bit in the same cycle leave the flag set.
- R11: Priority is line 0, then line 1, then the lowest-numbered maskable line. take_o is combinational from the registered state, and the taken flag clears at the next clock.
- R12: Register addresses are 0 for enable (read/write), 1 for flags (read-only), 2 for set and 3 for clear. Addresses 2 and 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 enable, 1 flags, 2 set, 3 clear |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_i | input | 16 | Raw interrupt lines, rising edge sensitive |
| gie_i | input | 1 | Global enable for maskable lines |
| nmi_ret_i | input | 1 | NMI return strobe; sets the NMI enable |
| take_o | output | 1 | Interrupt taken this cycle |
| take_idx_o | output | 4 | Index of the taken line |

## Verification
The bench sweeps every maskable line against all four combinations of the global enable and its own enable bit. A gate that ignored either input would fire where no take is expected. It drains twelve pending flags in a row and checks that the index steps up by one each cycle. A reversed priority or a flag that fails to clear would repeat an index or skip one.

The NMI enable is driven through each of its paths: a write of 0, a taken NMI, the return strobe, and a write of 1 in the same cycle as a taken NMI. A design that gave the write priority would leave the bit set and take the NMI a second time. The bench also holds a line high after its flag is cleared, which catches level-sensitive latching. It raises a line in the same cycle as a clear, which catches a clear that beats a set.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam int unsigned RST_IDX = 0;
  localparam int unsigned NMI_IDX = 1;

  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_FLAG = 2'd1,
    REG_SET  = 2'd2,
    REG_CLR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_gate_pkg::*;
#(
  parameter int unsigned NUM_IRQ    = 16,
  parameter int unsigned FIRST_MASK = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [NUM_IRQ-1:0] wdata_i,
  input  logic               nmi_ret_i,
  input  logic               nmi_taken_i,
  output logic [NUM_IRQ-1:0] en_o
);
  logic [NUM_IRQ-1:FIRST_MASK] ie_q;
  logic                        nmie_q;
  logic                        unused_bits;

  assign unused_bits = ^{wdata_i[RST_IDX], wdata_i[FIRST_MASK-1:NMI_IDX+1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ie_q <= '0;
    else if (wr_i) ie_q <= wdata_i[NUM_IRQ-1:FIRST_MASK];
  end

  // taken NMI beats any set request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nmie_q <= 1'b0;
    else if (nmi_taken_i) nmie_q <= 1'b0;
    else if ((wr_i && wdata_i[NMI_IDX]) || nmi_ret_i) nmie_q <= 1'b1;
  end

  always_comb begin
    en_o = '0;
    en_o[RST_IDX] = 1'b1;
    en_o[NMI_IDX] = nmie_q;
    en_o[NUM_IRQ-1:FIRST_MASK] = ie_q;
  end

  p_nmie_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmie_q && !nmi_taken_i |=> nmie_q);
  p_nmie_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nmie_q && !nmi_ret_i && !(wr_i && wdata_i[NMI_IDX]) |=> !nmie_q);
  p_nmie_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_taken_i |=> !nmie_q);
  p_nmie_ret_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_ret_i && !nmi_taken_i |=> nmie_q);
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg #(
  parameter int unsigned NUM_IRQ    = 16,
  parameter int unsigned FIRST_MASK = 4,
  localparam int unsigned IDX_W     = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               set_wr_i,
  input  logic               clr_wr_i,
  input  logic [NUM_IRQ-1:0] wdata_i,
  input  logic               take_i,
  input  logic [IDX_W-1:0]   take_idx_i,
  output logic [NUM_IRQ-1:0] flag_o
);
  logic [NUM_IRQ-1:0] prev_q, flag_q, valid, set_vec, clr_vec;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) valid[i] = (i < 2) || (i >= FIRST_MASK);
  end

  assign set_vec = ((irq_i & ~prev_q) | (set_wr_i ? wdata_i : '0)) & valid;
  assign clr_vec = (clr_wr_i ? wdata_i : '0) |
                   (take_i ? (NUM_IRQ'(1) << take_idx_i) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= irq_i;
      flag_q <= (flag_q & ~clr_vec) | set_vec;
    end
  end

  assign flag_o = flag_q;

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(set_vec)) == $past(set_vec)));
  p_take_clr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !set_vec[take_idx_i] |=> !flag_q[$past(take_idx_i)]);
  p_rsv_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & ~valid) == '0));
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_gate_pkg::*;
#(
  parameter int unsigned NUM_IRQ    = 16,
  parameter int unsigned FIRST_MASK = 4,
  localparam int unsigned IDX_W     = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic               gie_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_IRQ-1:0] elig;

  always_comb begin
    elig = '0;
    elig[RST_IDX] = pend_i[RST_IDX];
    elig[NMI_IDX] = pend_i[NMI_IDX] & en_i[NMI_IDX];
    for (int i = FIRST_MASK; i < NUM_IRQ; i++)
      elig[i] = pend_i[i] & en_i[i] & en_i[NMI_IDX] & gie_i;
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (elig[i]) idx_o = IDX_W'(i);
  end

  assign take_o = |elig;

  p_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && (idx_o != IDX_W'(RST_IDX)) |-> en_i[NMI_IDX]);
  p_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && (idx_o >= IDX_W'(FIRST_MASK)) |-> gie_i && en_i[idx_o]);
  p_pend_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> pend_i[idx_o]);
  p_rst_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_i[RST_IDX] |-> take_o && (idx_o == IDX_W'(RST_IDX)));
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_IRQ    = 16,
  parameter int unsigned FIRST_MASK = 4,
  localparam int unsigned IDX_W     = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               gie_i,
  input  logic               nmi_ret_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   take_idx_o
);
  reg_sel_e           sel;
  logic [NUM_IRQ-1:0] wd, en, flags;
  logic               en_wr, set_wr, clr_wr, nmi_taken;
  logic               unused_hi;

  assign sel       = reg_sel_e'(reg_addr_i);
  assign wd        = reg_wdata_i[NUM_IRQ-1:0];
  assign unused_hi = ^reg_wdata_i[DATA_W-1:NUM_IRQ];
  assign en_wr     = reg_we_i && (sel == REG_EN);
  assign set_wr    = reg_we_i && (sel == REG_SET);
  assign clr_wr    = reg_we_i && (sel == REG_CLR);
  assign nmi_taken = take_o && (take_idx_o == IDX_W'(NMI_IDX));

  irq_enable_reg #(.NUM_IRQ(NUM_IRQ), .FIRST_MASK(FIRST_MASK)) u_en (
    .clk_i, .rst_ni, .wr_i(en_wr), .wdata_i(wd), .nmi_ret_i,
    .nmi_taken_i(nmi_taken), .en_o(en)
  );

  irq_flag_reg #(.NUM_IRQ(NUM_IRQ), .FIRST_MASK(FIRST_MASK)) u_flag (
    .clk_i, .rst_ni, .irq_i, .set_wr_i(set_wr), .clr_wr_i(clr_wr),
    .wdata_i(wd), .take_i(take_o), .take_idx_i(take_idx_o), .flag_o(flags)
  );

  irq_prio_sel #(.NUM_IRQ(NUM_IRQ), .FIRST_MASK(FIRST_MASK)) u_sel (
    .clk_i, .rst_ni, .pend_i(flags), .en_i(en), .gie_i,
    .take_o, .idx_o(take_idx_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (sel)
      REG_EN:   reg_rdata_o[NUM_IRQ-1:0] = en;
      REG_FLAG: reg_rdata_o[NUM_IRQ-1:0] = flags;
      default:  reg_rdata_o = '0;
    endcase
  end

  p_take_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && !irq_i[take_idx_o] && !(set_wr && wd[take_idx_o])
    |=> !(take_o && take_idx_o == $past(take_idx_o)));
endmodule

// File: tb/tb_irq_gate_ctrl.sv
module tb_irq_gate_ctrl;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [15:0] irq_i = '0;
  logic        gie_i = 1'b0, nmi_ret_i = 1'b0;
  logic        take_o;
  logic [3:0]  take_idx_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_gate_ctrl dut (.*);

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, reg_rdata_o, exp);
  endtask

  task automatic tk(input string req, input bit t, input int idx);
    #1;
    if (t) chk(req, {27'd0, take_o, take_idx_o}, {27'd0, 1'b1, 4'(idx)});
    else   chk(req, {31'd0, take_o}, 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    // R1 R2 R3 R12 reset state
    rd("R1 R2 R3 reset enable", 2'd0, 32'h1);
    rd("R12 reset flags", 2'd1, 32'h0);
    rd("R12 set reads 0", 2'd2, 32'h0);
    rd("R12 clear reads 0", 2'd3, 32'h0);
    tk("R11 idle", 0, 0);

    // R2 R3 R8 write all ones, then zeros
    wr(2'd0, 32'hFFFF_FFFF);
    rd("R3 R8 write ones", 2'd0, 32'h0000_FFF3);
    wr(2'd0, 32'h0);
    rd("R1 R3 write zero keeps nmie", 2'd0, 32'h3);
    for (int k = 4; k < 16; k++) begin
      wr(2'd0, 32'(1) << k);
      rd("R2 single enable", 2'd0, (32'(1) << k) | 32'h3);
    end

    // R8 R10 set/clear with gie low
    gie_i = 1'b0;
    wr(2'd0, 32'h0000_FFF0);
    wr(2'd2, 32'hFFFF_FFFC);
    rd("R8 R10 set ignores reserved", 2'd1, 32'h0000_FFF0);
    tk("R7 gie low blocks", 0, 0);
    wr(2'd3, 32'h0000_00F0);
    rd("R10 clear", 2'd1, 32'h0000_FF00);
    wr(2'd3, 32'hFFFF_FFFF);
    rd("R10 clear all", 2'd1, 32'h0);

    // R10 edge set beats clear
    irq_i = 16'h0020;
    wr(2'd3, 32'h20);
    rd("R10 set wins", 2'd1, 32'h20);
    wr(2'd3, 32'h20);
    rd("R9 R10 held line no reset", 2'd1, 32'h0);
    irq_i = '0;
    cyc();

    // R11 priority drain
    gie_i = 1'b1;
    wr(2'd2, 32'h0000_FFF0);
    for (int k = 4; k < 16; k++) begin
      tk("R11 drain order", 1, k);
      cyc();
    end
    tk("R11 drained", 0, 0);
    rd("R11 flags empty", 2'd1, 32'h0);

    // R7 gate sweep
    for (int k = 4; k < 16; k++)
      for (int g = 0; g < 2; g++)
        for (int e = 0; e < 2; e++) begin
          gie_i = g[0];
          wr(2'd0, 32'(e) << k);
          wr(2'd2, 32'(1) << k);
          tk("R7 gate", (g == 1) && (e == 1), k);
          wr(2'd3, 32'(1) << k);
        end
    rd("R7 sweep flags empty", 2'd1, 32'h0);

    // R4 R5 R6 NMI enable paths
    gie_i = 1'b1;
    wr(2'd0, 32'h10);
    irq_i = 16'h0002;
    cyc();
    tk("R11 nmi taken", 1, 1);
    cyc();
    irq_i = '0;
    rd("R4 nmie cleared by nmi", 2'd0, 32'h11);
    wr(2'd0, 32'h10);
    rd("R3 zero write no effect", 2'd0, 32'h11);
    wr(2'd2, 32'h12);
    rd("R6 flags pending", 2'd1, 32'h12);
    tk("R6 blocked", 0, 0);
    wr(2'd2, 32'h1);
    tk("R6 reset still taken", 1, 0);
    cyc();
    nmi_ret_i = 1'b1;
    cyc();
    nmi_ret_i = 1'b0;
    rd("R5 nmi return sets", 2'd0, 32'h13);
    tk("R5 R11 nmi over maskable", 1, 1);
    cyc();
    tk("R4 R6 blocked after nmi", 0, 0);
    wr(2'd2, 32'h2);
    tk("R6 nmi blocked", 0, 0);
    wr(2'd0, 32'h12);
    tk("R3 write one enables nmi", 1, 1);
    wr(2'd0, 32'h12);
    rd("R4 take beats write", 2'd0, 32'h11);
    tk("R4 no retake", 0, 0);
    wr(2'd0, 32'h12);
    tk("R7 maskable after nmie", 1, 4);
    cyc();
    tk("R11 empty", 0, 0);

    // R9 level held
    wr(2'd0, 32'h42);
    irq_i = 16'h0040;
    cyc();
    tk("R9 edge sets flag", 1, 6);
    cyc();
    tk("R9 held no retake", 0, 0);
    cyc();
    tk("R9 held no retake 2", 0, 0);
    rd("R9 flags empty", 2'd1, 32'h0);
    irq_i = '0;
    cyc();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule